// File: doc/BRIEF.md
# System Protection Guard: Software Watchdog and Bus Timeout Monitor

This block guards a processor subsystem in two independent ways. A software watchdog counts system clocks while it is enabled. Software must service it before the count reaches the selected timeout. Servicing takes two ordered byte writes, 0x55 and then 0xAA, to a service register. When the timeout is reached, the block either raises a sticky interrupt request or issues a one-cycle reset request, depending on a select bit. A reset request also sets a flag in a status register.

The second part is a bus timeout monitor. It starts timing when a bus transfer begins and stops when the transfer is acknowledged. If the acknowledge does not arrive within the selected number of clocks, it emits a one-cycle bus-error strobe. Either counter can be held while a debug freeze input is high; a separate configuration bit enables this for each counter.

Software reaches the block through a byte-wide register port. The register map is:

- address 0: freeze configuration
- address 1: protection control
- address 2: interrupt vector
- address 3: service (write only, reads as 0x00)
- address 4: reset status

Read data is registered. It appears one cycle after the address is presented.

Top module: `sysprot_guard`

## Requirements
- R1: After reset the outputs `wd_irq`, `wd_rst_req` and `bus_err` are low. The control register reads 0x00 and the reset status register reads 0x80.
- R2: The control register (address 1) enables the watchdog with bit 7. Bit 5 selects the long range. Bits 4:3 hold a timing code. When the watchdog is first enabled, the timeout fires on the Nth clock edge after the enabling write. With bit 5 clear, codes 0 to 3 give N = 2^9, 2^11, 2^13 and 2^15. With bit 5 set, codes 0 to 3 give N = 2^(L), 2^(L+2), 2^(L+4) and 2^(L+6), where L is `WD_LONG_EXP` (default 18).
- R3: Writing 0x55 and then 0xAA to the service register (address 3) restarts the watchdog count from zero and clears `wd_irq`. Writes to other registers between the two keys do not break the pair. The next expiry follows 2^exp edges after the 0xAA write.
- R4: Any service write other than the expected next key returns the sequence to waiting for 0x55. Such a write does not restart the count. A 0xAA with no 0x55 armed before it has no effect.
- R5: Control bit 6 selects what expiry does. With bit 6 = 0, expiry raises `wd_irq`. `wd_irq` stays high across later expiries until a completed key pair is written.
- R6: With bit 6 = 1, expiry drives `wd_rst_req` high for exactly one cycle. It also sets bit 5 of the reset status register.
- R7: Reset status bit 7 (hard reset) and bit 5 (watchdog reset) each clear when a 1 is written to that bit at address 4. Writing 0 to a bit leaves it unchanged.
- R8: Control bit 2 enables the bus monitor. Bits 1:0 select the limit: codes 0 to 3 give 1024, 512, 256 and 128 clocks. If no acknowledge arrives, `bus_err` goes high for exactly one cycle on that many clock edges after the `bus_start` edge.
- R9: `bus_ack` stops the bus monitor, and no `bus_err` follows for that transfer.
- R10: While `freeze_in` is high, freeze configuration bit 7 (address 0) holds the watchdog count. Bit 6 of the same register holds the bus monitor count. Counting resumes from the held value when `freeze_in` falls.
- R11: The vector register (address 2) reads back the value last written to it and drives `wd_vector`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| freeze_in | input | 1 | Debug freeze request |
| bus_start | input | 1 | Bus transfer start strobe |
| bus_ack | input | 1 | Bus transfer acknowledge |
| wd_irq | output | 1 | Sticky watchdog interrupt request |
| wd_rst_req | output | 1 | One-cycle watchdog reset request |
| wd_vector | output | 8 | Stored watchdog interrupt vector |
| bus_err | output | 1 | One-cycle bus timeout strobe |

## Verification
A table walks all four bus monitor codes and three watchdog timeouts, including one in the long range. Each case is sampled one cycle before and exactly at the expected edge, so an off-by-one or a swapped code is caught.

Directed key patterns cover:
- a clean pair;
- a pair with another register write between the keys;
- a lone 0xAA;
- a pair broken by a wrong byte.

These show which writes restart the count and which are ignored.

Further cases cover:
- an acknowledged transfer and frozen counters, which separate pausing from clearing;
- reset-mode expiry with write-one-to-clear status, which shows the pulse width and that each flag clears independently.

// File: rtl/sysprot_pkg.sv
package sysprot_pkg;
  localparam int REG_W = 8;

  typedef enum logic [2:0] {
    A_FREEZE = 3'd0,
    A_CTRL   = 3'd1,
    A_VEC    = 3'd2,
    A_SVC    = 3'd3,
    A_STAT   = 3'd4
  } reg_addr_e;

  localparam logic [REG_W-1:0] KEY_ARM  = 8'h55;
  localparam logic [REG_W-1:0] KEY_FIRE = 8'hAA;

  // control register field positions
  localparam int C_WD_EN   = 7;
  localparam int C_WD_RST  = 6;
  localparam int C_WD_LONG = 5;
  localparam int C_WD_TLO  = 3;
  localparam int C_BM_EN   = 2;
  localparam int C_BM_TLO  = 0;

  // freeze and status bit positions
  localparam int F_WD   = 7;
  localparam int F_BM   = 6;
  localparam int S_HARD = 7;
  localparam int S_WDOG = 5;
endpackage

// File: rtl/wd_key_seq.sv
module wd_key_seq
  import sysprot_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             svc_wr,
  input  logic [REG_W-1:0] svc_data,
  output logic             svc_done
);
  logic armed;

  assign svc_done = svc_wr && armed && (svc_data == KEY_FIRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (svc_wr) begin
      armed <= (svc_data == KEY_ARM);
    end
  end
endmodule

// File: rtl/wd_core.sv
module wd_core #(
  parameter int SHORT_EXP = 9,
  parameter int LONG_EXP  = 18,
  localparam int CW       = LONG_EXP + 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          rst_mode,
  input  logic          long_rng,
  input  logic [1:0]    tsel,
  input  logic          hold,
  input  logic          service,
  output logic          rst_req,
  output logic          irq,
  output logic [CW-1:0] count
);
  logic [5:0]  expo;
  logic [CW:0] lim;
  logic        last;

  always_comb begin
    expo = (long_rng ? 6'(LONG_EXP) : 6'(SHORT_EXP)) + {3'b000, tsel, 1'b0};
    lim  = (CW+1)'(1) << expo;
    last = (count == (lim[CW-1:0] - CW'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (service) begin
        count <= '0;
        irq   <= 1'b0;
      end else if (!en) begin
        count <= '0;
      end else if (!hold) begin
        if (last) begin
          count <= '0;
          if (rst_mode) rst_req <= 1'b1;
          else          irq     <= 1'b1;
        end else begin
          count <= count + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/bus_mon.sv
module bus_mon #(
  parameter int MAX_EXP = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] tsel,
  input  logic       hold,
  input  logic       start,
  input  logic       ack,
  output logic       err
);
  localparam int CW = MAX_EXP;

  logic [CW-1:0] bcnt;
  logic [CW:0]   lim;
  logic          active;
  logic          last;

  always_comb begin
    lim  = (CW+1)'(1) << (MAX_EXP - int'(tsel));
    last = (bcnt == (lim[CW-1:0] - CW'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt   <= '0;
      active <= 1'b0;
      err    <= 1'b0;
    end else begin
      err <= 1'b0;
      if (start) begin
        active <= 1'b1;
        bcnt   <= '0;
      end else if (ack) begin
        active <= 1'b0;
      end else if (active && en && !hold) begin
        if (last) begin
          err    <= 1'b1;
          active <= 1'b0;
        end else begin
          bcnt <= bcnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sysprot_guard.sv
module sysprot_guard
  import sysprot_pkg::*;
#(
  parameter int WD_SHORT_EXP = 9,
  parameter int WD_LONG_EXP  = 18,
  parameter int BM_MAX_EXP   = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       freeze_in,
  input  logic       bus_start,
  input  logic       bus_ack,
  output logic       wd_irq,
  output logic       wd_rst_req,
  output logic [7:0] wd_vector,
  output logic       bus_err
);
  localparam int WD_CW = WD_LONG_EXP + 6;

  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] vec_q;
  logic             frz_wd, frz_bm;
  logic             hard_flag, wd_flag;
  logic             svc_done;
  logic             wd_en;
  logic [WD_CW-1:0] wd_count;

  wire wr_freeze = reg_wr && (reg_addr == A_FREEZE);
  wire wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
  wire wr_vec    = reg_wr && (reg_addr == A_VEC);
  wire wr_svc    = reg_wr && (reg_addr == A_SVC);
  wire wr_stat   = reg_wr && (reg_addr == A_STAT);

  assign wd_en     = ctrl_q[C_WD_EN];
  assign wd_vector = vec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      vec_q     <= '0;
      frz_wd    <= 1'b0;
      frz_bm    <= 1'b0;
      hard_flag <= 1'b1;
      wd_flag   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata;
      if (wr_vec)  vec_q  <= reg_wdata;
      if (wr_freeze) begin
        frz_wd <= reg_wdata[F_WD];
        frz_bm <= reg_wdata[F_BM];
      end
      if (wr_stat && reg_wdata[S_HARD]) hard_flag <= 1'b0;
      if (wd_rst_req)                   wd_flag   <= 1'b1;
      else if (wr_stat && reg_wdata[S_WDOG]) wd_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_addr)
        A_FREEZE: reg_rdata <= {frz_wd, frz_bm, 6'b0};
        A_CTRL:   reg_rdata <= ctrl_q;
        A_VEC:    reg_rdata <= vec_q;
        A_STAT:   reg_rdata <= {hard_flag, 1'b0, wd_flag, 5'b0};
        default:  reg_rdata <= '0;
      endcase
    end
  end

  wd_key_seq u_key (
    .clk      (clk),
    .rst      (rst),
    .svc_wr   (wr_svc),
    .svc_data (reg_wdata),
    .svc_done (svc_done)
  );

  wd_core #(
    .SHORT_EXP (WD_SHORT_EXP),
    .LONG_EXP  (WD_LONG_EXP)
  ) u_wd (
    .clk      (clk),
    .rst      (rst),
    .en       (wd_en),
    .rst_mode (ctrl_q[C_WD_RST]),
    .long_rng (ctrl_q[C_WD_LONG]),
    .tsel     (ctrl_q[C_WD_TLO +: 2]),
    .hold     (freeze_in && frz_wd),
    .service  (svc_done),
    .rst_req  (wd_rst_req),
    .irq      (wd_irq),
    .count    (wd_count)
  );

  bus_mon #(
    .MAX_EXP (BM_MAX_EXP)
  ) u_bm (
    .clk   (clk),
    .rst   (rst),
    .en    (ctrl_q[C_BM_EN]),
    .tsel  (ctrl_q[C_BM_TLO +: 2]),
    .hold  (freeze_in && frz_bm),
    .start (bus_start),
    .ack   (bus_ack),
    .err   (bus_err)
  );
endmodule

// File: rtl/sysprot_guard_chk.sv
module sysprot_guard_chk #(
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic [7:0]    reg_wdata,
  input logic          freeze_in,
  input logic          bus_start,
  input logic          bus_ack,
  input logic          wd_irq,
  input logic          wd_rst_req,
  input logic          bus_err,
  input logic          wd_flag,
  input logic          frz_wd,
  input logic          wd_en,
  input logic [CW-1:0] wd_count
);
  p_rst_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    wd_rst_req |=> !wd_rst_req);

  p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
    wd_rst_req |=> wd_flag);

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    bus_err |=> !bus_err);

  p_ack_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_ack && !bus_start) |=> !bus_err);

  p_irq_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (wd_irq && !(reg_wr && reg_addr == 3'd3 && reg_wdata == 8'hAA)) |=> wd_irq);

  p_freeze_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (freeze_in && frz_wd && wd_en &&
     !(reg_wr && (reg_addr == 3'd3 || reg_addr == 3'd1))) |=> $stable(wd_count));
endmodule

bind sysprot_guard sysprot_guard_chk #(.CW(WD_CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .freeze_in  (freeze_in),
  .bus_start  (bus_start),
  .bus_ack    (bus_ack),
  .wd_irq     (wd_irq),
  .wd_rst_req (wd_rst_req),
  .bus_err    (bus_err),
  .wd_flag    (wd_flag),
  .frz_wd     (frz_wd),
  .wd_en      (wd_en),
  .wd_count   (wd_count)
);

// File: tb/sim_sysprot_guard.sv
module sim_sysprot_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       freeze_in = 1'b0;
  logic       bus_start = 1'b0;
  logic       bus_ack = 1'b0;
  logic       wd_irq, wd_rst_req, bus_err;
  logic [7:0] wd_vector;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int err_seen = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (bus_err) err_seen <= err_seen + 1;

  sysprot_guard #(.WD_LONG_EXP(12)) u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .freeze_in(freeze_in),
    .bus_start(bus_start), .bus_ack(bus_ack), .wd_irq(wd_irq),
    .wd_rst_req(wd_rst_req), .wd_vector(wd_vector), .bus_err(bus_err)
  );

  // kind (0 bus, 1 watchdog) | control byte | expected edge count
  localparam logic [31:0] CASES [7] = '{
    {8'd0, 8'h04, 16'd1024}, {8'd0, 8'h05, 16'd512},
    {8'd0, 8'h06, 16'd256},  {8'd0, 8'h07, 16'd128},
    {8'd1, 8'h80, 16'd512},  {8'd1, 8'h88, 16'd2048},
    {8'd1, 8'hA0, 16'd4096}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic pulse_start();
    @(negedge clk); bus_start = 1'b1;
    @(negedge clk); bus_start = 1'b0;
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", wd_irq, 0);
    check("R1 rst_req", wd_rst_req, 0);
    check("R1 bus_err", bus_err, 0);
    rd(3'd1, d); check("R1 ctrl", d, 8'h00);
    rd(3'd4, d); check("R1 status", d, 8'h80);

    // R11 vector register
    wr(3'd2, 8'h3C);
    rd(3'd2, d); check("R11 readback", d, 8'h3C);
    check("R11 port", wd_vector, 8'h3C);

    // table walk: R2 watchdog ranges, R8 bus codes
    for (int i = 0; i < 7; i++) begin
      int n;
      n = int'(CASES[i][15:0]);
      wr(3'd1, CASES[i][23:16]);
      if (CASES[i][31:24] == 8'd0) begin
        pulse_start();
        base = cyc;
        wait_to(base + n - 1); check("R8 early", bus_err, 0);
        wait_to(base + n);     check("R8 fire", bus_err, 1);
        wait_to(base + n + 1); check("R8 one cycle", bus_err, 0);
      end else begin
        base = cyc;
        wait_to(base + n - 1); check("R2 early", wd_irq, 0);
        wait_to(base + n);     check("R2 fire", wd_irq, 1);
        wr(3'd3, 8'h55); wr(3'd3, 8'hAA);
        check("R3 irq cleared", wd_irq, 0);
      end
      wr(3'd1, 8'h00);
    end

    // R3 pair with another write between, R4 broken sequences do not reload
    wr(3'd1, 8'h80);
    wait_to(cyc + 300);
    wr(3'd3, 8'h55); wr(3'd2, 8'h11); wr(3'd3, 8'hAA);
    base = cyc;
    wr(3'd3, 8'hAA);
    wr(3'd3, 8'h55); wr(3'd3, 8'h00); wr(3'd3, 8'hAA);
    wait_to(base + 511); check("R4 no reload", wd_irq, 0);
    wait_to(base + 512); check("R3 reload point", wd_irq, 1);

    // R5 sticky through later expiry, R4 lone or broken keys ignored
    wait_to(base + 1200); check("R5 sticky", wd_irq, 1);
    wr(3'd3, 8'hAA); check("R4 lone AA", wd_irq, 1);
    wr(3'd3, 8'h55); wr(3'd3, 8'h12); wr(3'd3, 8'hAA);
    check("R4 broken pair", wd_irq, 1);
    wr(3'd3, 8'h55); wr(3'd3, 8'hAA);
    check("R5 cleared by pair", wd_irq, 0);
    wr(3'd1, 8'h00);

    // R6 reset mode, R7 write-one-to-clear
    wr(3'd1, 8'hC0);
    base = cyc;
    wait_to(base + 511); check("R6 early", wd_rst_req, 0);
    wait_to(base + 512); check("R6 pulse", wd_rst_req, 1);
    check("R6 no irq", wd_irq, 0);
    wait_to(base + 513); check("R6 one cycle", wd_rst_req, 0);
    wr(3'd1, 8'h00);
    rd(3'd4, d); check("R6 status", d, 8'hA0);
    wr(3'd4, 8'h20);
    rd(3'd4, d); check("R7 clear wd flag", d, 8'h80);
    wr(3'd4, 8'h00);
    rd(3'd4, d); check("R7 zero write", d, 8'h80);
    wr(3'd4, 8'h80);
    rd(3'd4, d); check("R7 clear hard flag", d, 8'h00);

    // R9 acknowledge stops the bus monitor
    wr(3'd1, 8'h07);
    base = err_seen;
    pulse_start();
    wait_to(cyc + 100);
    @(negedge clk); bus_ack = 1'b1;
    @(negedge clk); bus_ack = 1'b0;
    wait_to(cyc + 300);
    check("R9 no error after ack", err_seen, base);

    // R10 freeze of bus monitor
    wr(3'd0, 8'h40);
    rd(3'd0, d); check("R10 freeze cfg", d, 8'h40);
    freeze_in = 1'b1;
    base = err_seen;
    pulse_start();
    wait_to(cyc + 300);
    check("R10 bus held", err_seen, base);
    freeze_in = 1'b0;
    base = cyc;
    wait_to(base + 127); check("R10 bus early", bus_err, 0);
    wait_to(base + 128); check("R10 bus resumes", bus_err, 1);
    wr(3'd1, 8'h00);

    // R10 freeze of watchdog
    wr(3'd0, 8'h80);
    freeze_in = 1'b1;
    wr(3'd1, 8'h80);
    wait_to(cyc + 700); check("R10 wd held", wd_irq, 0);
    freeze_in = 1'b0;
    base = cyc;
    wait_to(base + 511); check("R10 wd early", wd_irq, 0);
    wait_to(base + 512); check("R10 wd resumes", wd_irq, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule